// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch-table slot, chosen by a few low bits of the branch address, holds a group of two-bit saturating counters. A global history register records the directions of the most recently resolved branches, whichever branches they were. Its value picks which counter of the group supplies the prediction. Because every branch shares this history, the direction of one branch can steer the prediction for the branch that follows it.

A lookup is combinational. The front end presents an index and receives a taken or not-taken prediction, together with the history value that selected the counter. When the branch resolves, the back end returns the same index, that saved history value and the actual direction. On the next clock edge the block trains the selected counter and shifts the outcome into the global history.

The history length `HIST_LEN` may be 0, 1 or 2. A length of 0 gives a plain predictor with one two-bit counter per table slot.

Top module: `cbp_predictor`

## Requirements
- R1: Each counter holds one of four states, encoded as 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken and 3 = strong taken. `lk_taken` is 1 exactly when the selected counter is in state 2 or 3.
- R2: An update moves the selected counter one step toward state 3 when the outcome is taken, and one step toward state 0 when it is not taken. The counter saturates at 3 and at 0 and never wraps.
- R3: Reset is synchronous and active high. It puts every counter in state 0 and clears the global history to all not-taken.
- R4: On an update the global history shifts left by one and takes the new outcome into bit 0, so bit 0 always holds the most recent outcome. Without an update the history holds its value.
- R5: A lookup reads the counter addressed by `lk_idx` together with the current history value. It shows that history value on `lk_hist` in the same cycle.
- R6: An update trains the counter addressed by `up_idx` and `up_hist`, which is the history captured at lookup, and not the counter that the current history would select.
- R7: The history is shared by all table slots, so an update for one index changes which counter a later lookup of a different index reads.
- R8: With `HIST_LEN` = 0 there is a single counter per index, and `up_hist` has no effect on which counter is trained.
- R9: The prediction depends only on the current inputs and state, with no clock cycle of latency. The effects of an update are visible from the clock edge that samples `up_valid`.
- R10: Replaying d = 0, 2, 0, 2, 0, 2, 0, 2 through two dependent branches gives these correct-prediction counts per branch out of 8. Branch one (index 0) is taken when d is not 0. Branch two (index 1) follows after d = 0 is changed to 1, and is taken when d is not 1. The counts are 4 and 4 for `HIST_LEN` 0, 6 and 6 for length 1, and 6 and 6 for length 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_idx | input | IDX_W | Table index of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | max(HIST_LEN,1) | History value used for this lookup, kept for the update |
| up_valid | input | 1 | An update is presented this cycle |
| up_idx | input | IDX_W | Table index of the resolved branch |
| up_hist | input | max(HIST_LEN,1) | History captured when that branch was predicted |
| up_taken | input | 1 | Actual direction, 1 = taken |

## Verification
A prediction and its history value are due in the same cycle as the lookup index. The bench therefore samples them 1 ns after driving the index at a falling edge, well before the next rising edge. An update is driven at a falling edge and applied at the following rising edge. The bench reads the trained counter and the shifted history only at the falling edge after that rising edge, so no check falls on the edge itself. Three instances, with history lengths 2, 1 and 0, receive the same stimulus. This lets the replay compare the three configurations in one pass.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    // one saturating training step
    function automatic ctr_t ctr_train(ctr_t c, logic taken);
        ctr_t n;
        n = c;
        if (taken) begin
            if (c != CTR_ST) n = ctr_t'(c + 2'd1);
        end else begin
            if (c != CTR_SNT) n = ctr_t'(c - 2'd1);
        end
        return n;
    endfunction

    function automatic logic ctr_says_taken(ctr_t c);
        return (c == CTR_WT) || (c == CTR_ST);
    endfunction

    // a zero-length history still travels on a one-bit port
    function automatic int unsigned hist_w(int unsigned len);
        return (len == 0) ? 1 : len;
    endfunction

endpackage

// File: rtl/cbp_history.sv
module cbp_history #(
    parameter  int unsigned HIST_LEN = 2,
    localparam int unsigned HW       = cbp_pkg::hist_w(HIST_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          shift_in,
    output logic [HW-1:0] hist
);

    generate
        if (HIST_LEN == 0) begin : g_none
            logic unused_hist_in;
            assign unused_hist_in = ^{clk, rst, shift_en, shift_in};
            assign hist = '0;
        end else if (HIST_LEN == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           hist <= '0;
                else if (shift_en) hist <= shift_in;
            end
        end else begin : g_many
            // newest outcome enters at bit 0
            always_ff @(posedge clk) begin
                if (rst)           hist <= '0;
                else if (shift_en) hist <= {hist[HW-2:0], shift_in};
            end
        end
    endgenerate

endmodule

// File: rtl/cbp_ctr_table.sv
module cbp_ctr_table
    import cbp_pkg::*;
#(
    parameter  int unsigned IDX_W    = 4,
    parameter  int unsigned HIST_LEN = 2,
    localparam int unsigned HW       = cbp_pkg::hist_w(HIST_LEN),
    localparam int unsigned AW       = IDX_W + HIST_LEN,
    localparam int unsigned DEPTH    = 1 << AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [HW-1:0]    rd_hist,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [HW-1:0]    wr_hist,
    input  logic             wr_taken
);

    logic [AW-1:0] ra;
    logic [AW-1:0] wa;
    ctr_t          tbl [DEPTH];

    generate
        if (HIST_LEN == 0) begin : g_flat
            logic unused_tbl_hist;
            assign unused_tbl_hist = ^{rd_hist, wr_hist};
            assign ra = rd_idx;
            assign wa = wr_idx;
        end else begin : g_corr
            assign ra = {rd_idx, rd_hist};
            assign wa = {wr_idx, wr_hist};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_SNT;
        end else if (wr_en) begin
            tbl[wa] <= ctr_train(tbl[wa], wr_taken);
        end
    end

    assign rd_ctr = tbl[ra];

    // R2: taken never lowers a counter, not-taken never raises it
    a_r2_taken_dir: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=> (tbl[$past(wa)] >= $past(tbl[wa])));
    a_r2_not_taken_dir: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken) |=> (tbl[$past(wa)] <= $past(tbl[wa])));
    // R2: no wrap at either end
    a_r2_sat_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && tbl[wa] == CTR_ST) |=> (tbl[$past(wa)] == CTR_ST));
    a_r2_sat_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && tbl[wa] == CTR_SNT) |=> (tbl[$past(wa)] == CTR_SNT));

endmodule

// File: rtl/cbp_predictor.sv
module cbp_predictor
    import cbp_pkg::*;
#(
    parameter  int unsigned IDX_W    = 4,
    parameter  int unsigned HIST_LEN = 2,
    localparam int unsigned HW       = cbp_pkg::hist_w(HIST_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_taken,
    output logic [HW-1:0]    lk_hist,
    input  logic             up_valid,
    input  logic [IDX_W-1:0] up_idx,
    input  logic [HW-1:0]    up_hist,
    input  logic             up_taken
);

    logic [HW-1:0] ghist;
    ctr_t          sel_ctr;

    cbp_history #(.HIST_LEN(HIST_LEN)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (up_valid),
        .shift_in (up_taken),
        .hist     (ghist)
    );

    cbp_ctr_table #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_hist  (ghist),
        .rd_ctr   (sel_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_hist  (up_hist),
        .wr_taken (up_taken)
    );

    assign lk_taken = ctr_says_taken(sel_ctr);
    assign lk_hist  = ghist;

    // R3: straight after reset every counter predicts not-taken
    a_r3_reset_not_taken: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_taken);
    // R4: history holds when there is no update
    a_r4_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(lk_hist));

    generate
        if (HIST_LEN > 0) begin : g_hist_chk
            // R4: newest outcome lands in bit 0
            a_r4_lsb_newest: assert property (@(posedge clk) disable iff (rst)
                up_valid |=> (lk_hist[0] == $past(up_taken)));
        end
        if (HIST_LEN > 1) begin : g_shift_chk
            // R4: older outcome moves up one place
            a_r4_shift_left: assert property (@(posedge clk) disable iff (rst)
                up_valid |=> (lk_hist[1] == $past(lk_hist[0])));
        end
    endgenerate

endmodule

// File: tb/sim_cbp_predictor.sv
module sim_cbp_predictor;

    localparam int unsigned IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] lk_idx = '0;
    logic          up_valid = 1'b0;
    logic [IW-1:0] up_idx = '0;
    logic          up_taken = 1'b0;

    logic [1:0] up_hist2 = '0;
    logic [0:0] up_hist1 = '0;
    logic [0:0] up_hist0 = '0;
    logic       p2, p1, p0;
    logic [1:0] h2;
    logic [0:0] h1, h0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 8 ns period

    cbp_predictor #(.IDX_W(IW), .HIST_LEN(2)) u0 (
        .clk(clk), .rst(rst), .lk_idx(lk_idx), .lk_taken(p2), .lk_hist(h2),
        .up_valid(up_valid), .up_idx(up_idx), .up_hist(up_hist2), .up_taken(up_taken));
    cbp_predictor #(.IDX_W(IW), .HIST_LEN(1)) u_m1 (
        .clk(clk), .rst(rst), .lk_idx(lk_idx), .lk_taken(p1), .lk_hist(h1),
        .up_valid(up_valid), .up_idx(up_idx), .up_hist(up_hist1), .up_taken(up_taken));
    cbp_predictor #(.IDX_W(IW), .HIST_LEN(0)) u_m0 (
        .clk(clk), .rst(rst), .lk_idx(lk_idx), .lk_taken(p0), .lk_hist(h0),
        .up_valid(up_valid), .up_idx(up_idx), .up_hist(up_hist0), .up_taken(up_taken));

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        up_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // lookup: combinational, sampled 1 ns after the index settles
    task automatic look(input logic [IW-1:0] idx);
        @(negedge clk);
        lk_idx = idx;
        #1;
    endtask

    // update applied at the next rising edge, visible at the falling edge after it
    task automatic upd(input logic [IW-1:0] idx, input logic tk,
                       input logic [1:0] hv2, input logic hv1, input logic hv0);
        @(negedge clk);
        up_idx = idx; up_taken = tk;
        up_hist2 = hv2; up_hist1 = hv1; up_hist0 = hv0;
        up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 16; i++) begin
            look(i[IW-1:0]);
            check("R3 counters clear (len2)", p2, 0);
            check("R3 counters clear (len0)", p0, 0);
        end
        check("R3 history clear", h2, 0);
        check("R3 history clear len1", h1, 0);
    endtask

    task automatic t_saturate();
        do_reset();
        // not-taken at state 0 stays at 0: one taken gives state 1, still not-taken
        upd(4'd5, 1'b0, 2'b00, 1'b0, 1'b0);
        upd(4'd5, 1'b1, 2'b00, 1'b0, 1'b0);
        look(4'd5);
        check("R2 no wrap below state 0 (len0)", p0, 0);
        for (int i = 0; i < 4; i++) upd(4'd5, 1'b1, 2'b00, 1'b0, 1'b0);
        look(4'd5);
        check("R1 strong taken predicts taken (len0)", p0, 1);
        upd(4'd5, 1'b0, 2'b00, 1'b0, 1'b0);
        look(4'd5);
        check("R2 saturated at 3, one step down stays taken", p0, 1);
        upd(4'd5, 1'b0, 2'b00, 1'b0, 1'b0);
        look(4'd5);
        check("R1 weak not-taken predicts not-taken", p0, 0);
    endtask

    task automatic t_history();
        do_reset();
        upd(4'd3, 1'b1, 2'b00, 1'b0, 1'b0);
        look(4'd0);
        check("R4 taken enters bit 0", h2, 2'b01);
        check("R9 history visible after one edge", h1, 1);
        upd(4'd3, 1'b0, 2'b00, 1'b0, 1'b0);
        look(4'd0);
        check("R4 shift left", h2, 2'b10);
        repeat (3) @(negedge clk);
        check("R4 history holds without update", h2, 2'b10);
        upd(4'd3, 1'b1, 2'b00, 1'b0, 1'b0);
        upd(4'd3, 1'b1, 2'b00, 1'b0, 1'b0);
        look(4'd0);
        check("R4 two taken outcomes", h2, 2'b11);
    endtask

    task automatic t_captured_hist();
        do_reset();
        // train index 3 under saved history 10 while live history moves to 11
        upd(4'd3, 1'b1, 2'b10, 1'b0, 1'b0);
        upd(4'd3, 1'b1, 2'b10, 1'b0, 1'b0);
        look(4'd3);
        check("R6 live history 11 reads an untrained counter", p2, 0);
        check("R5 lk_hist reports live history", h2, 2'b11);
        upd(4'd9, 1'b0, 2'b00, 1'b0, 1'b0);   // live history -> 10
        look(4'd3);
        check("R6 counter chosen by captured history", p2, 1);
    endtask

    task automatic t_shared();
        do_reset();
        upd(4'd1, 1'b1, 2'b01, 1'b0, 1'b0);
        upd(4'd1, 1'b1, 2'b01, 1'b0, 1'b0);
        upd(4'd7, 1'b0, 2'b00, 1'b0, 1'b0);   // 11 -> 10
        upd(4'd7, 1'b1, 2'b00, 1'b0, 1'b0);   // 10 -> 01
        look(4'd1);
        check("R5 index 1 with history 01 predicts taken", p2, 1);
        upd(4'd9, 1'b1, 2'b00, 1'b0, 1'b0);   // 01 -> 11
        look(4'd1);
        check("R7 other branch outcome changes prediction", p2, 0);
    endtask

    task automatic t_flat();
        do_reset();
        upd(4'd2, 1'b1, 2'b00, 1'b0, 1'b0);
        upd(4'd2, 1'b1, 2'b00, 1'b1, 1'b1);
        look(4'd2);
        check("R8 len0 trains one counter whatever up_hist", p0, 1);
        check("R8 len1 splits by history (contrast)", p1, 0);
    endtask

    task automatic t_replay();
        int c2 [2];
        int c1 [2];
        int c0 [2];
        logic [1:0] s2;
        logic [0:0] s1, s0;
        for (int b = 0; b < 2; b++) begin c2[b] = 0; c1[b] = 0; c0[b] = 0; end
        do_reset();
        for (int k = 0; k < 8; k++) begin
            int d;
            d = (k % 2 == 0) ? 0 : 2;
            for (int b = 0; b < 2; b++) begin
                logic act;
                if (b == 0) act = (d != 0);
                else begin
                    if (d == 0) d = 1;
                    act = (d != 1);
                end
                look(b[IW-1:0]);
                s2 = h2; s1 = h1; s0 = h0;
                if (p2 == act) c2[b]++;
                if (p1 == act) c1[b]++;
                if (p0 == act) c0[b]++;
                up_idx = b[IW-1:0]; up_taken = act;
                up_hist2 = s2; up_hist1 = s1; up_hist0 = s0;
                up_valid = 1'b1;
                @(negedge clk);
                up_valid = 1'b0;
            end
        end
        check("R10 len0 branch one correct", c0[0], 4);
        check("R10 len0 branch two correct", c0[1], 4);
        check("R10 len1 branch one correct", c1[0], 6);
        check("R10 len1 branch two correct", c1[1], 6);
        check("R10 len2 branch one correct", c2[0], 6);
        check("R10 len2 branch two correct", c2[1], 6);
    endtask

    initial begin
        t_reset();
        t_saturate();
        t_history();
        t_captured_hist();
        t_shared();
        t_flat();
        t_replay();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule